// File: doc/BRIEF.md
# Downstream Port Power and Over-current Manager

This block owns the power switches of a hub's downstream ports. Hub control logic asks for power to be turned on or off, and the block drives one active-low enable line per port. An external power switch pulls that line low to power its port. Each port also returns an active-low over-current line. The block filters that line against a 1 µs time tick, so the inrush current of a newly attached device is not mistaken for a fault.

A fault is confirmed only after the line has stayed low for a fixed number of consecutive ticks while the port is powered. A confirmed fault cuts power and sets two flags for the hub status logic. The status flag reports that the port is locked out. The change flag is sticky and must be cleared explicitly before power can be requested again.

A mode input selects how the ports are controlled. In individual mode every port has its own power and its own faults. In ganged mode the ports are switched as one group, and a fault on any port shuts the whole group down.

Top module: `pwr_oc_mgr`

## Requirements
- R1: During and right after a cycle with `rst` high, every bit of `pwr_en_n` is 1 (power off), and every bit of `oc_status` and `oc_change` is 0.
- R2: In individual mode, a pulse on `pwr_on_req[i]` drives `pwr_en_n[i]` low on the next clock. A pulse on `pwr_off_req[i]` drives it high on the next clock. Other ports are unaffected.
- R3: While `pwr_en_n[i]` is high, `oc_n[i]` is ignored. Holding it low for any length of time sets no flag and changes no output.
- R4: A fault on port i is confirmed at the THRESH-th tick that finds `oc_n[i]` low, counting only consecutive ticks while the port is powered. If `oc_n[i]` returns high earlier, the count restarts. `pwr_en_n[i]` goes high on the clock that follows the confirming tick.
- R5: In individual mode, a confirmed fault on port i turns that port off and sets `oc_status[i]` and `oc_change[i]`. Every other port keeps its power and its flags.
- R6: In ganged mode, a power-on or power-off pulse on any bit applies to all ports. A confirmed fault on any port turns all ports off and sets the status and change flags of every port.
- R7: `oc_change[i]` stays set until a pulse on `oc_chg_clr[i]`. A power-on request is refused while `oc_change[i]` is set; in ganged mode it is refused while any change flag is set. A granted power-on clears `oc_status` for the ports it powers.
- R8: A confirmed fault takes priority over a clear pulse in the same cycle. A power-off request takes priority over a power-on request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| gang_mode | input | 1 | 1 = ports switched as one group, 0 = individual |
| oc_n | input | NUM_PORTS | Over-current reports, low = over-current |
| pwr_on_req | input | NUM_PORTS | Power-on request pulses |
| pwr_off_req | input | NUM_PORTS | Power-off request pulses |
| oc_chg_clr | input | NUM_PORTS | Clear pulses for the change flags |
| pwr_en_n | output | NUM_PORTS | Power enables, low = power on |
| oc_status | output | NUM_PORTS | Port locked out by a confirmed fault |
| oc_change | output | NUM_PORTS | Sticky flag, set when a fault is confirmed |

## Verification
The bench builds the block with four ports and a threshold of 20 ticks, and it pulses the tick every third clock. With these values the trip point, a release one tick short of it, and a full ganged shutdown each fit in a few hundred clocks. Ticks that arrive between clocks also test that the filter counts ticks rather than cycles. Four ports are enough to show that a fault spreads to every port in ganged mode and stays on one port in individual mode. They also allow an unpowered port to sit with its over-current line held low throughout.

// File: rtl/pwr_oc_pkg.sv
package pwr_oc_pkg;
  // Width of a counter able to hold values 0..limit.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/oc_glitch_filter.sv
module oc_glitch_filter #(
  parameter int THRESH = 550,
  parameter int CW     = pwr_oc_pkg::cnt_width(THRESH)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic armed,   // port power is on
  input  logic oc_n,
  output logic trip
);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;
  logic          qual;

  assign qual = armed && !oc_n;
  assign trip = qual && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !qual) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/port_pwr_ctl.sv
module port_pwr_ctl #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gang_mode,
  input  logic [NUM_PORTS-1:0] trip,
  input  logic [NUM_PORTS-1:0] on_req,
  input  logic [NUM_PORTS-1:0] off_req,
  input  logic [NUM_PORTS-1:0] chg_clr,
  output logic [NUM_PORTS-1:0] pwr_off_q,
  output logic [NUM_PORTS-1:0] status_q,
  output logic [NUM_PORTS-1:0] change_q
);
  logic [NUM_PORTS-1:0] fault, grant, cut;
  logic any_trip, any_chg, any_on, any_off;

  assign any_trip = |trip;
  assign any_chg  = |change_q;
  assign any_on   = |on_req;
  assign any_off  = |off_req;

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (gang_mode) begin
        fault[i] = any_trip;
        cut[i]   = any_off;
        grant[i] = any_on && !any_chg;
      end else begin
        fault[i] = trip[i];
        cut[i]   = off_req[i];
        grant[i] = on_req[i] && !change_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_off_q <= '1;
      status_q  <= '0;
      change_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (fault[i]) begin
          pwr_off_q[i] <= 1'b1;
          status_q[i]  <= 1'b1;
          change_q[i]  <= 1'b1;
        end else begin
          if (cut[i]) begin
            pwr_off_q[i] <= 1'b1;
          end else if (grant[i]) begin
            pwr_off_q[i] <= 1'b0;
            status_q[i]  <= 1'b0;
          end
          if (chg_clr[i]) change_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwr_oc_mgr.sv
module pwr_oc_mgr #(
  parameter int NUM_PORTS = 7,
  parameter int THRESH    = 550
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_1us,
  input  logic                 gang_mode,
  input  logic [NUM_PORTS-1:0] oc_n,
  input  logic [NUM_PORTS-1:0] pwr_on_req,
  input  logic [NUM_PORTS-1:0] pwr_off_req,
  input  logic [NUM_PORTS-1:0] oc_chg_clr,
  output logic [NUM_PORTS-1:0] pwr_en_n,
  output logic [NUM_PORTS-1:0] oc_status,
  output logic [NUM_PORTS-1:0] oc_change
);
  localparam int CW = pwr_oc_pkg::cnt_width(THRESH);

  logic [NUM_PORTS-1:0] trip;
  logic [NUM_PORTS-1:0] pwr_off_q;

  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_filt
      oc_glitch_filter #(.THRESH(THRESH), .CW(CW)) filt_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_1us),
        .armed (!pwr_off_q[g]),
        .oc_n  (oc_n[g]),
        .trip  (trip[g])
      );
    end
  endgenerate

  port_pwr_ctl #(.NUM_PORTS(NUM_PORTS)) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .gang_mode (gang_mode),
    .trip      (trip),
    .on_req    (pwr_on_req),
    .off_req   (pwr_off_req),
    .chg_clr   (oc_chg_clr),
    .pwr_off_q (pwr_off_q),
    .status_q  (oc_status),
    .change_q  (oc_change)
  );

  assign pwr_en_n = pwr_off_q;
endmodule

// File: rtl/pwr_oc_mgr_chk.sv
module pwr_oc_mgr_chk #(
  parameter int NUM_PORTS = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 gang_mode,
  input logic [NUM_PORTS-1:0] oc_n,
  input logic [NUM_PORTS-1:0] pwr_on_req,
  input logic [NUM_PORTS-1:0] pwr_off_req,
  input logic [NUM_PORTS-1:0] oc_chg_clr,
  input logic [NUM_PORTS-1:0] pwr_en_n,
  input logic [NUM_PORTS-1:0] oc_status,
  input logic [NUM_PORTS-1:0] oc_change
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pwr_en_n == '1 && oc_status == '0 && oc_change == '0));

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      assert_power_cut_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en_n[i]) |-> ($past(!oc_n[i]) || $past(pwr_off_req[i]) || $past(gang_mode)));
      assert_unpowered_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(oc_change[i]) && !$past(gang_mode)) |-> !$past(pwr_en_n[i]));
      assert_fault_flags_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_change[i]) |-> (oc_status[i] && pwr_en_n[i]));
      assert_change_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (oc_change[i] && !oc_chg_clr[i]) |=> oc_change[i]);
      assert_no_power_while_flagged_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en_n[i]) |-> !$past(oc_change[i]));
      assert_off_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (!gang_mode && pwr_off_req[i]) |=> pwr_en_n[i]);
    end
  endgenerate
endmodule

bind pwr_oc_mgr pwr_oc_mgr_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .gang_mode   (gang_mode),
  .oc_n        (oc_n),
  .pwr_on_req  (pwr_on_req),
  .pwr_off_req (pwr_off_req),
  .oc_chg_clr  (oc_chg_clr),
  .pwr_en_n    (pwr_en_n),
  .oc_status   (oc_status),
  .oc_change   (oc_change)
);

// File: tb/pwr_oc_mgr_tb_top.sv
`timescale 1ns/1ps
module pwr_oc_mgr_tb_top;
  localparam int N  = 4;
  localparam int TH = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         gang = 1'b0;
  logic [N-1:0] oc_n = '1;
  logic [N-1:0] on_req = '0;
  logic [N-1:0] off_req = '0;
  logic [N-1:0] clr = '0;
  logic [N-1:0] pwr_en_n, oc_status, oc_change;

  int  checks = 0;
  int  fails = 0;
  int  cyc = 0;
  bit  done = 0;

  int  m_cnt [N];
  bit  m_off [N];
  bit  m_st  [N];
  bit  m_ch  [N];

  always #4 clk = ~clk;

  pwr_oc_mgr #(.NUM_PORTS(N), .THRESH(TH)) dut_i (
    .clk(clk), .rst(rst), .tick_1us(tick), .gang_mode(gang),
    .oc_n(oc_n), .pwr_on_req(on_req), .pwr_off_req(off_req),
    .oc_chg_clr(clr), .pwr_en_n(pwr_en_n), .oc_status(oc_status),
    .oc_change(oc_change)
  );

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Behavioural reference: one clock of the requirements R1..R8.
  task automatic step();
    int  n_cnt [N];
    bit  n_off [N], n_st [N], n_ch [N];
    bit  trip [N];
    bit  any_trip = 0, any_ch = 0, any_on = 0, any_off = 0;
    for (int i = 0; i < N; i++) begin
      trip[i] = !m_off[i] && !oc_n[i] && tick && (m_cnt[i] == TH - 1);
      any_trip |= trip[i];
      any_ch   |= m_ch[i];
      any_on   |= on_req[i];
      any_off  |= off_req[i];
    end
    for (int i = 0; i < N; i++) begin
      bit f, c, g;
      f = gang ? any_trip : trip[i];
      c = gang ? any_off : off_req[i];
      g = gang ? (any_on && !any_ch) : (on_req[i] && !m_ch[i]);
      n_off[i] = m_off[i]; n_st[i] = m_st[i]; n_ch[i] = m_ch[i];
      if (m_off[i] || oc_n[i]) n_cnt[i] = 0;
      else if (tick) n_cnt[i] = (m_cnt[i] == TH - 1) ? 0 : m_cnt[i] + 1;
      else n_cnt[i] = m_cnt[i];
      if (f) begin
        n_off[i] = 1; n_st[i] = 1; n_ch[i] = 1;
      end else begin
        if (c) n_off[i] = 0 == 1 ? 0 : 1;
        else if (g) begin n_off[i] = 0; n_st[i] = 0; end
        if (clr[i]) n_ch[i] = 0;
      end
      if (rst) begin
        n_cnt[i] = 0; n_off[i] = 1; n_st[i] = 0; n_ch[i] = 0;
      end
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = n_cnt[i]; m_off[i] = n_off[i]; m_st[i] = n_st[i]; m_ch[i] = n_ch[i];
    end
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      expect_bit($sformatf("R2 pwr_en_n[%0d] cycle %0d", i, cyc), pwr_en_n[i], m_off[i]);
      expect_bit($sformatf("R5 oc_status[%0d] cycle %0d", i, cyc), oc_status[i], m_st[i]);
      expect_bit($sformatf("R7 oc_change[%0d] cycle %0d", i, cyc), oc_change[i], m_ch[i]);
    end
    cyc++;
    tick = (cyc % 3 == 0);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic pulse_on(input logic [N-1:0] v);
    on_req = v; step(); on_req = '0;
  endtask

  task automatic pulse_off(input logic [N-1:0] v);
    off_req = v; step(); off_req = '0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] v);
    clr = v; step(); clr = '0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = 0; m_off[i] = 1; m_st[i] = 0; m_ch[i] = 0;
    end
    @(negedge clk);
    run(3);
    rst = 1'b0;
    // R1: reset state at the ports
    expect_bit("R1 pwr_en_n", &pwr_en_n, 1'b1);
    expect_bit("R1 oc_status", |oc_status, 1'b0);
    expect_bit("R1 oc_change", |oc_change, 1'b0);

    // R2: individual power on of ports 0 and 1
    pulse_on(4'b0011);
    expect_bit("R2 port0 on", pwr_en_n[0], 1'b0);
    expect_bit("R2 port2 untouched", pwr_en_n[2], 1'b1);

    // R3: over-current on unpowered port 2, held well past the threshold
    oc_n[2] = 1'b0;
    run(3 * TH + 30);
    expect_bit("R3 no change flag on unpowered port", oc_change[2], 1'b0);
    expect_bit("R3 no status on unpowered port", oc_status[2], 1'b0);
    oc_n[2] = 1'b1;

    // R4: glitch one tick short of the threshold, then restart
    oc_n[0] = 1'b0;
    while (m_cnt[0] != TH - 1) step();
    oc_n[0] = 1'b1;
    run(6);
    expect_bit("R4 short glitch keeps power", pwr_en_n[0], 1'b0);

    // R4/R5: held fault trips port 0 only
    oc_n[0] = 1'b0;
    run(3 * TH + 6);
    expect_bit("R4 port0 cut after filter", pwr_en_n[0], 1'b1);
    expect_bit("R5 port1 keeps power", pwr_en_n[1], 1'b0);
    expect_bit("R5 port0 status", oc_status[0], 1'b1);
    expect_bit("R5 port1 no flag", oc_change[1], 1'b0);
    oc_n[0] = 1'b1;

    // R7: refused while flagged, granted after clear
    pulse_on(4'b0001);
    expect_bit("R7 refused while flagged", pwr_en_n[0], 1'b1);
    run(5);
    expect_bit("R7 flag sticky", oc_change[0], 1'b1);
    pulse_clr(4'b0001);
    expect_bit("R7 flag cleared", oc_change[0], 1'b0);
    pulse_on(4'b0001);
    expect_bit("R7 power after clear", pwr_en_n[0], 1'b0);
    expect_bit("R7 status cleared by grant", oc_status[0], 1'b0);

    // R8: off and on together -> off; fault beats a held clear
    on_req = 4'b0010; off_req = 4'b0010; step(); on_req = '0; off_req = '0;
    expect_bit("R8 off wins", pwr_en_n[1], 1'b1);
    clr[0] = 1'b1; oc_n[0] = 1'b0;
    run(3 * TH + 6);
    expect_bit("R8 status survives held clear", oc_status[0], 1'b1);
    clr[0] = 1'b0; oc_n[0] = 1'b1;
    pulse_clr('1);
    pulse_off('1);

    // R6: ganged control and fault spread
    gang = 1'b1;
    pulse_on(4'b1000);
    expect_bit("R6 gang on port0", pwr_en_n[0], 1'b0);
    expect_bit("R6 gang on port2", pwr_en_n[2], 1'b0);
    oc_n[1] = 1'b0;
    run(3 * TH + 6);
    oc_n[1] = 1'b1;
    expect_bit("R6 gang all off", |(~pwr_en_n), 1'b0);
    expect_bit("R6 gang all flagged", &oc_change, 1'b1);
    pulse_clr(4'b0111);
    pulse_on(4'b0001);
    expect_bit("R7 gang refused while any flag", pwr_en_n[0], 1'b1);
    pulse_clr(4'b1000);
    pulse_on(4'b0001);
    expect_bit("R6 gang on after clear", pwr_en_n[3], 1'b0);
    pulse_off(4'b0100);
    expect_bit("R6 gang off", pwr_en_n[3], 1'b1);
    run(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule